// File: doc/BRIEF.md
# Dual Countdown Timer with Interrupt Aggregation

Two independent down-counters sit behind a word-addressed register file. Each counter has a reload value, a live count that can be read back, and a control register. A small field in the control register picks which of four external tick strobes advances the counter. The remaining codes of that field park the counter.

A tick that arrives while a counter is at zero reloads it and raises that counter's bit in a shared raw status vector. The status is gated by a mask register, and the single interrupt line is the OR of the gated bits. Software clears status bits by writing ones to an acknowledge register. Writes are single-cycle strobes. Reads are combinational from the address.

Top module: `dual_tick_timer`

## Requirements
- R1: After synchronous reset, every count, reload, control, mask and status register reads 0, and `irq` is low.
- R2: A write to a timer's reload register (timer n at byte offset 0x10*n) or its control register (offset 0x10*n+0x08) loads the counter from the reload value in force after that write. The new count reads back from the count register (offset 0x10*n+0x04) one cycle later. A load overrides a tick in the same cycle.
- R3: Control bits [2:0] hold the tick source code. Codes 4, 5, 6 and 7 select `tick_en[0]`, `[1]`, `[2]` and `[3]`. Codes 0 to 3 hold the count unchanged whatever the strobes do. Control reads back as those three bits, zero-extended.
- R4: A strobe on the selected source while the count is non-zero decrements the count by exactly one. Strobes on the other sources have no effect on the count.
- R5: A selected strobe while the count is zero reloads the counter from the reload register and sets raw status bit n (bit 0 for timer0, bit 1 for timer1). The counter then keeps running, so a timer expires once every reload+1 selected strobes.
- R6: A write to the acknowledge register (offset 0x4C) clears each raw status bit whose position holds a 1 in the written data, and leaves the other bits alone.
- R7: When an expiry and an acknowledge of the same bit fall in one cycle, the bit ends set.
- R8: The mask register (offset 0x48, bits [1:0]) reads back as written. Offset 0x54 reads raw status AND mask, and `irq` is high exactly when that value is non-zero.
- R9: Reads of any other byte address, including the acknowledge register and misaligned addresses, return 0. Writes to unmapped addresses change no register.
- R10: The two timers are independent. Activity on one changes neither the count nor the registers of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 7 | Byte address of the register access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| tick_en | input | 4 | External tick strobes, one per selectable rate |
| irq | output | 1 | Interrupt, high while any unmasked status bit is set |

## Verification
Expiry and acknowledge can fall in the same cycle, and this is where the status logic is most easily wrong. The bench provokes it by driving the acknowledge write and the selected tick strobe for one timer, which is sitting at zero, in a single cycle. It then reads the masked status and `irq` and expects the bit still set. In the same cycle it acknowledges the other timer's bit, and it expects that bit cleared, which separates the set-wins rule from a blanket ignore of the acknowledge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;
    localparam int N_TMR  = 2;
    localparam int N_SRC  = 4;
    localparam int SRC_W  = 3;

    // per-timer register stride and slot offsets
    localparam logic [ADDR_W-1:0] TMR_STRIDE = 7'h10;
    localparam logic [ADDR_W-1:0] SLOT_RELOAD = 7'h00;
    localparam logic [ADDR_W-1:0] SLOT_COUNT  = 7'h04;
    localparam logic [ADDR_W-1:0] SLOT_CTRL   = 7'h08;

    // shared interrupt registers
    localparam logic [ADDR_W-1:0] OFS_MASK   = 7'h48;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 7'h4C;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 7'h54;

    typedef struct packed {
        logic [N_TMR-1:0] reload_we;
        logic [N_TMR-1:0] ctrl_we;
        logic             mask_we;
        logic             ack_we;
    } wr_sel_t;

    function automatic logic [ADDR_W-1:0] tmr_addr(input int idx,
                                                   input logic [ADDR_W-1:0] slot);
        return ADDR_W'(idx * int'(TMR_STRIDE)) + slot;
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_sel_t           sel
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_TMR; i++) begin
            sel.reload_we[i] = wr_en && (addr == tmr_addr(i, SLOT_RELOAD));
            sel.ctrl_we[i]   = wr_en && (addr == tmr_addr(i, SLOT_CTRL));
        end
        sel.mask_we = wr_en && (addr == OFS_MASK);
        sel.ack_we  = wr_en && (addr == OFS_ACK);
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int CNT_W = 32,
    parameter int SRC_W = 3,
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload_we,
    input  logic             ctrl_we,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [N_SRC-1:0] tick_en,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic [SRC_W-1:0] ctrl,
    output logic             hit
);
    localparam int SRC_BASE = (1 << SRC_W) - N_SRC;
    localparam int SEL_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [CNT_W-1:0] count_q, reload_q, reload_d;
    logic [SRC_W-1:0] ctrl_q;
    logic [SEL_W-1:0] src_idx;
    logic             src_live, tick_sel, load;

    always_comb begin
        src_live = (ctrl_q >= SRC_W'(SRC_BASE));
        src_idx  = SEL_W'(ctrl_q - SRC_W'(SRC_BASE));
        tick_sel = src_live && tick_en[src_idx];
        load     = reload_we || ctrl_we;
        reload_d = reload_we ? wr_data : reload_q;
        hit      = !load && tick_sel && (count_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (reload_we) reload_q <= wr_data;
            if (ctrl_we)   ctrl_q   <= wr_data[SRC_W-1:0];
            if (load)
                count_q <= reload_d;
            else if (tick_sel)
                count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
        end
    end

    assign count  = count_q;
    assign reload = reload_q;
    assign ctrl   = ctrl_q;

    AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        load |=> (count_q == reload_q)); // R2
    AST_PARKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!load && !src_live) |=> $stable(count_q)); // R3
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && tick_sel && count_q != '0) |=> (count_q == $past(count_q) - 1'b1)); // R4
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!load && tick_sel && count_q == '0) |=> (count_q == $past(reload_q))); // R5
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int N_TMR = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_TMR-1:0] hit,
    input  logic             mask_we,
    input  logic             ack_we,
    input  logic [N_TMR-1:0] wr_bits,
    output logic [N_TMR-1:0] mask,
    output logic [N_TMR-1:0] masked,
    output logic             irq
);
    logic [N_TMR-1:0] raw_q, mask_q, clr;

    always_comb clr = ack_we ? wr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr) | hit;
            if (mask_we) mask_q <= wr_bits;
        end
    end

    assign mask   = mask_q;
    assign masked = raw_q & mask_q;
    assign irq    = |masked;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((raw_q & $past(hit)) == $past(hit))); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ack_we |=> ((raw_q & $past(wr_bits) & ~$past(hit)) == '0)); // R6
    AST_ACK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        ack_we |=> ((raw_q & ~$past(wr_bits)) == ($past(raw_q) & ~$past(wr_bits)) | $past(hit) & ~$past(wr_bits))); // R6
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_SRC-1:0]  tick_en,
    output logic              irq
);
    wr_sel_t          sel;
    logic [CNT_W-1:0] count  [N_TMR];
    logic [CNT_W-1:0] reload [N_TMR];
    logic [SRC_W-1:0] ctrl   [N_TMR];
    logic [N_TMR-1:0] hit, mask, masked;

    tmr_decode u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .sel   (sel)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        tmr_channel #(
            .CNT_W (CNT_W),
            .SRC_W (SRC_W),
            .N_SRC (N_SRC)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .reload_we (sel.reload_we[g]),
            .ctrl_we   (sel.ctrl_we[g]),
            .wr_data   (wr_data[CNT_W-1:0]),
            .tick_en   (tick_en),
            .count     (count[g]),
            .reload    (reload[g]),
            .ctrl      (ctrl[g]),
            .hit       (hit[g])
        );
    end

    tmr_irq #(.N_TMR(N_TMR)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .mask_we (sel.mask_we),
        .ack_we  (sel.ack_we),
        .wr_bits (wr_data[N_TMR-1:0]),
        .mask    (mask),
        .masked  (masked),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (addr == tmr_addr(i, SLOT_RELOAD)) rd_data = DATA_W'(reload[i]);
            if (addr == tmr_addr(i, SLOT_COUNT))  rd_data = DATA_W'(count[i]);
            if (addr == tmr_addr(i, SLOT_CTRL))   rd_data = DATA_W'(ctrl[i]);
        end
        if (addr == OFS_MASK)   rd_data = DATA_W'(mask);
        if (addr == OFS_MASKED) rd_data = DATA_W'(masked);
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !irq); // R1
endmodule

// File: tb/test_dual_tick_timer.sv
module test_dual_tick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  tick_en = '0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_tick_timer i_dual_tick_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .tick_en(tick_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tick(input logic [3:0] p);
        @(negedge clk);
        tick_en = p;
        @(negedge clk);
        tick_en = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        foreach (i_dummy[k]) ;
        for (int a = 0; a < 128; a += 4) begin
            rd(7'(a), v);
            chk("R1", v, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2: load on reload write and on control write
        wr(7'h00, 32'd77);
        rd(7'h04, v); chk("R2 reload write", v, 32'd77);
        wr(7'h08, 32'h4);
        tick(4'b0001);
        rd(7'h04, v); chk("R2 tick", v, 32'd76);
        wr(7'h08, 32'h4);
        rd(7'h04, v); chk("R2 ctrl write reloads", v, 32'd77);
        // R2: load beats a tick in the same cycle
        @(negedge clk);
        wr_en = 1'b1; addr = 7'h00; wr_data = 32'd9; tick_en = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; tick_en = '0;
        rd(7'h04, v); chk("R2 load over tick", v, 32'd9);

        // R3, R4, R10: sweep timer, source code and strobe
        for (int t = 0; t < 2; t++) begin
            wr(7'(16 * (1 - t) + 8), 32'h0);
            wr(7'(16 * (1 - t)), 32'd50);
            for (int code = 0; code < 8; code++) begin
                for (int s = 0; s < 4; s++) begin
                    wr(7'(16 * t), 32'd5);
                    wr(7'(16 * t + 8), 32'(code));
                    rd(7'(16 * t + 8), v); chk("R3 ctrl readback", v, 32'(code));
                    tick(4'(1 << s));
                    rd(7'(16 * t + 4), v);
                    if (code >= 4 && s == code - 4) chk("R4 step", v, 32'd4);
                    else chk("R3 R4 hold", v, 32'd5);
                    rd(7'(16 * (1 - t) + 4), v); chk("R10 other count", v, 32'd50);
                end
            end
        end

        // R5, R8, R6: expiry, periodic reload, acknowledge
        wr(7'h18, 32'h0);
        wr(7'h48, 32'h3);
        rd(7'h48, v); chk("R8 mask readback", v, 32'h3);
        for (int d = 0; d < 4; d++) begin
            wr(7'h00, 32'(d));
            wr(7'h08, 32'h4);
            wr(7'h4C, 32'h3);
            for (int rep = 0; rep < 2; rep++) begin
                for (int k = 0; k < d; k++) tick(4'b0001);
                rd(7'h54, v); chk("R5 no early expiry", v, 32'h0);
                chk("R8 irq low", {31'b0, irq}, 32'h0);
                tick(4'b0001);
                rd(7'h54, v); chk("R5 expiry", v, 32'h1);
                chk("R8 irq high", {31'b0, irq}, 32'h1);
                rd(7'h04, v); chk("R5 reload", v, 32'(d));
                wr(7'h4C, 32'h1);
                rd(7'h54, v); chk("R6 ack", v, 32'h0);
            end
        end

        // R8: mask sweep with both raw bits set
        wr(7'h00, 32'h0); wr(7'h08, 32'h4);
        wr(7'h10, 32'h0); wr(7'h18, 32'h5);
        tick(4'b0011);
        for (int m = 0; m < 4; m++) begin
            wr(7'h48, 32'(m));
            rd(7'h54, v); chk("R8 masked", v, 32'(m));
            chk("R8 irq", {31'b0, irq}, {31'b0, m != 0});
        end
        // R6: partial acknowledge
        wr(7'h4C, 32'h2);
        rd(7'h54, v); chk("R6 partial", v, 32'h1);

        // R7: expiry and acknowledge in one cycle
        tick(4'b0010);
        rd(7'h54, v); chk("R7 setup", v, 32'h3);
        @(negedge clk);
        wr_en = 1'b1; addr = 7'h4C; wr_data = 32'h3; tick_en = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; tick_en = '0;
        rd(7'h54, v); chk("R7 set wins", v, 32'h1);
        chk("R7 irq", {31'b0, irq}, 32'h1);
        wr(7'h4C, 32'h1);

        // R9: unmapped accesses
        wr(7'h00, 32'd33); wr(7'h08, 32'h0);
        foreach (unm[k]) begin
            wr(unm[k], 32'hFFFF_FFFF);
            rd(unm[k], v); chk("R9 unmapped read", v, 32'h0);
        end
        rd(7'h00, v); chk("R9 reload kept", v, 32'd33);
        rd(7'h04, v); chk("R9 count kept", v, 32'd33);
        rd(7'h08, v); chk("R9 ctrl kept", v, 32'h0);
        rd(7'h48, v); chk("R9 mask kept", v, 32'h3);
        rd(7'h54, v); chk("R9 status kept", v, 32'h0);
        rd(7'h4C, v); chk("R9 ack reads zero", v, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [6:0] unm [5] = '{7'h01, 7'h0C, 7'h20, 7'h50, 7'h7C};
    logic       i_dummy [1];

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule